// File: doc/BRIEF.md
# Road Stream End-of-Event Formatter

This block sits on a single road link between the pattern-matching chips and the aggregator output. Each cycle it takes one 32-bit word with four K-flags from the matching chips. Road words are passed on to the output unchanged. Every other word is replaced by the output idle code.

The matching chips never send an explicit end of event, so the block works it out for itself. An INIT_event pulse arms the block and starts a cycle counter. After a programmable latency has run out, the first cycle in which the input is not a road word closes the event. In that cycle the block emits the end-of-event word, which carries the event ID and error bits, and it raises a one-cycle pulse toward the control logic.

Each INIT_event produces exactly one end of event. Road words that arrive while the block is not armed are dropped, and each one sets a sticky flag. An enable input freezes the block and forces the idle code onto the output. All outputs are registered, so each output word appears one clock after the input cycle that decided it.

Top module: `road_eoe_fmt`

## Requirements
- R1: After reset the output carries 0x0000BC50 with K-flags 0010, the end-event pulse is low and the late-road flag is low. The block is disarmed.
- R2: A road word is an input with K-flags 0000, whose bits 31:24 hold the bitmap and bits 23:0 the road ID. While the block is armed, or in the INIT_event cycle itself, a road word appears unchanged on the output one cycle later with K-flags 0000.
- R3: An input with any K-flags other than 0000 that does not close an event produces 0x0000BC50 with K-flags 0010 on the next cycle. The input idle word 0xBCBC1C1C with K-flags 1111 is one such input.
- R4: The end-of-event word has 0xF7 in bits 31:24, the error input in bits 23:16 and the event ID in bits 15:0, with K-flags 1000. Error and ID are taken from the cycle in which the event is closed.
- R5: Take INIT_event in cycle t0. Cycle t0+k may close the event only when k is at least the 16-bit latency setting N, and only when its input is not a road word. The first such cycle closes the event. With N = 0, the first non-road cycle after t0 closes it. The elapsed count saturates at 0xFFFF.
- R6: The end-event pulse is high in exactly the cycles in which the end-of-event word is on the output.
- R7: Each INIT_event yields at most one end-of-event word. A new INIT_event re-arms the block and restarts the count, even while the block is still armed. The INIT_event cycle never closes an event.
- R8: A road word that arrives while the block is disarmed is dropped and the output shows the idle code. The block is disarmed after an end of event, and after reset before the first INIT_event. Each such road word sets the late-road flag, which only reset clears.
- R9: While the enable is low, the output shows the idle code. INIT_event and the input words are ignored, the late-road flag is unchanged and the elapsed count is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| init_evt | input | 1 | INIT_event pulse, arms the block |
| lat_cfg | input | 16 | Latency N in cycles after INIT_event |
| evt_id | input | 16 | Event ID for the end-of-event word |
| err_code | input | 8 | Error bits for the end-of-event word |
| in_word | input | 32 | Word from the matching chips |
| in_k | input | 4 | K-flags of in_word |
| out_word | output | 32 | Word toward the aggregator |
| out_k | output | 4 | K-flags of out_word |
| eoe_pulse | output | 1 | End-event pulse toward the control logic |
| late_road | output | 1 | Sticky flag for dropped road words |

## Verification
The bench checks the exact cycle of closure at the latency boundary, one cycle before and at k = N. It also checks gaps that come before the latency has run out, which must not close the event, and the N = 0 case. A design whose comparison is off by one, or that closes on the first gap regardless of latency, emits its end word one cycle early or on an early gap.

It also checks that a re-arm in mid-event restarts the count, that a road word in the INIT_event cycle is forwarded, and that a K pattern which is neither idle nor road counts as a gap. Road words after closure and before the first INIT_event must be dropped and flagged. A design that misses this would forward them or emit a second end word.

Stretches with the enable low, carrying INIT_event and road words, must leave the state, the count and the flag untouched.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int WORD_W = 32;
  localparam int KF_W   = 4;

  localparam logic [WORD_W-1:0] OUT_IDLE_WORD = 32'h0000BC50;
  localparam logic [KF_W-1:0]   OUT_IDLE_K    = 4'b0010;
  localparam logic [KF_W-1:0]   ROAD_K        = 4'b0000;
  localparam logic [KF_W-1:0]   EOE_K         = 4'b1000;
  localparam logic [7:0]        EOE_TAG       = 8'hF7;

  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_ROAD = 2'd1,
    SEL_EOE  = 2'd2
  } out_sel_e;

  typedef enum logic {
    ST_DISARMED = 1'b0,
    ST_ARMED    = 1'b1
  } arm_st_e;
endpackage

// File: rtl/rsf_timer.sv
module rsf_timer #(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic [LAT_W-1:0] elapsed
);
  localparam logic [LAT_W-1:0] CNT_MAX = '1;
  localparam logic [LAT_W-1:0] CNT_ONE = LAT_W'(1);

  logic [LAT_W-1:0] elapsed_nxt;

  always_comb begin
    elapsed_nxt = elapsed;
    if (restart) begin
      elapsed_nxt = CNT_ONE;
    end else if (advance && (elapsed != CNT_MAX)) begin
      elapsed_nxt = elapsed + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (restart || advance) begin
      elapsed <= elapsed_nxt;
    end
  end
endmodule

// File: rtl/rsf_ctrl.sv
module rsf_ctrl
  import rsf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     init_evt,
  input  logic     is_road,
  input  logic     lat_met,
  output logic     restart,
  output logic     advance,
  output out_sel_e sel,
  output logic     late_flag
);
  arm_st_e st_q, st_n;
  logic    late_n;

  always_comb begin
    st_n    = st_q;
    late_n  = late_flag;
    sel     = SEL_IDLE;
    restart = 1'b0;
    advance = 1'b0;
    if (en) begin
      if (init_evt) begin
        restart = 1'b1;
        st_n    = ST_ARMED;
        if (is_road) sel = SEL_ROAD;
      end else if (st_q == ST_ARMED) begin
        advance = 1'b1;
        if (is_road) begin
          sel = SEL_ROAD;
        end else if (lat_met) begin
          sel  = SEL_EOE;
          st_n = ST_DISARMED;
        end
      end else if (is_road) begin
        late_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_DISARMED;
      late_flag <= 1'b0;
    end else begin
      st_q      <= st_n;
      late_flag <= late_n;
    end
  end
endmodule

// File: rtl/rsf_outreg.sv
module rsf_outreg
  import rsf_pkg::*;
#(
  parameter int ID_W  = 16,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  out_sel_e          sel,
  input  logic [WORD_W-1:0] in_word,
  input  logic [ID_W-1:0]   evt_id,
  input  logic [ERR_W-1:0]  err_code,
  output logic [WORD_W-1:0] out_word,
  output logic [KF_W-1:0]   out_k,
  output logic              eoe_pulse
);
  logic [WORD_W-1:0] word_n;
  logic [KF_W-1:0]   k_n;
  logic              pulse_n;

  always_comb begin
    word_n  = OUT_IDLE_WORD;
    k_n     = OUT_IDLE_K;
    pulse_n = 1'b0;
    unique case (sel)
      SEL_ROAD: begin
        word_n = in_word;
        k_n    = ROAD_K;
      end
      SEL_EOE: begin
        word_n  = {EOE_TAG, err_code, evt_id};
        k_n     = EOE_K;
        pulse_n = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word  <= OUT_IDLE_WORD;
      out_k     <= OUT_IDLE_K;
      eoe_pulse <= 1'b0;
    end else begin
      out_word  <= word_n;
      out_k     <= k_n;
      eoe_pulse <= pulse_n;
    end
  end
endmodule

// File: rtl/road_eoe_fmt.sv
module road_eoe_fmt
  import rsf_pkg::*;
#(
  parameter int LAT_W = 16,
  parameter int ID_W  = 16,
  parameter int ERR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 init_evt,
  input  logic [LAT_W-1:0]     lat_cfg,
  input  logic [ID_W-1:0]      evt_id,
  input  logic [ERR_W-1:0]     err_code,
  input  logic [WORD_W-1:0]    in_word,
  input  logic [KF_W-1:0]      in_k,
  output logic [WORD_W-1:0]    out_word,
  output logic [KF_W-1:0]      out_k,
  output logic                 eoe_pulse,
  output logic                 late_road
);
  logic             is_road;
  logic             lat_met;
  logic             restart;
  logic             advance;
  logic [LAT_W-1:0] elapsed;
  out_sel_e         sel;

  assign is_road = (in_k == ROAD_K);
  assign lat_met = (elapsed >= lat_cfg);

  rsf_timer #(.LAT_W(LAT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .advance (advance),
    .elapsed (elapsed)
  );

  rsf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .init_evt  (init_evt),
    .is_road   (is_road),
    .lat_met   (lat_met),
    .restart   (restart),
    .advance   (advance),
    .sel       (sel),
    .late_flag (late_road)
  );

  rsf_outreg #(.ID_W(ID_W), .ERR_W(ERR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .in_word   (in_word),
    .evt_id    (evt_id),
    .err_code  (err_code),
    .out_word  (out_word),
    .out_k     (out_k),
    .eoe_pulse (eoe_pulse)
  );
endmodule

// File: rtl/rsf_checker.sv
module rsf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [3:0]  in_k,
  input logic [31:0] out_word,
  input logic [3:0]  out_k,
  input logic        eoe_pulse,
  input logic        late_road
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_idle_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoe_pulse && out_k != 4'b0000) |-> (out_word == 32'h0000BC50 && out_k == 4'b0010));

  p_eoe_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoe_pulse |-> (out_k == 4'b1000 && out_word[31:24] == 8'hF7));

  p_gap_before_eoe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoe_pulse && past_ok) |-> ($past(in_k) != 4'b0000 && $past(en)));

  p_pulse_tracks_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_k == 4'b1000) |-> eoe_pulse);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoe_pulse |=> !eoe_pulse);

  p_late_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    late_road |=> late_road);

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(en)) |-> (!eoe_pulse && out_k == 4'b0010));
endmodule

bind road_eoe_fmt rsf_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .in_k      (in_k),
  .out_word  (out_word),
  .out_k     (out_k),
  .eoe_pulse (eoe_pulse),
  .late_road (late_road)
);

// File: tb/road_eoe_fmt_bench.sv
`timescale 1ns/1ps
module road_eoe_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        init_evt = 1'b0;
  logic [15:0] lat_cfg = 16'd0;
  logic [15:0] evt_id = 16'd0;
  logic [7:0]  err_code = 8'd0;
  logic [31:0] in_word = 32'hBCBC1C1C;
  logic [3:0]  in_k = 4'b1111;
  logic [31:0] out_word;
  logic [3:0]  out_k;
  logic        eoe_pulse;
  logic        late_road;

  int total = 0;
  int bad = 0;
  int dut_pulses = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] m_word;
  logic [3:0]  m_k;
  logic        m_pulse;
  logic        m_late;
  bit          m_armed;
  int          m_elapsed;

  always #4 clk = ~clk;

  road_eoe_fmt u_road_eoe_fmt (
    .clk(clk), .rst_n(rst_n), .en(en), .init_evt(init_evt), .lat_cfg(lat_cfg),
    .evt_id(evt_id), .err_code(err_code), .in_word(in_word), .in_k(in_k),
    .out_word(out_word), .out_k(out_k), .eoe_pulse(eoe_pulse), .late_road(late_road)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = 32'h0000BC50; m_k = 4'b0010; m_pulse = 0; m_late = 0;
      m_armed = 0; m_elapsed = 0;
    end else begin
      m_word = 32'h0000BC50; m_k = 4'b0010; m_pulse = 0;
      if (en) begin
        if (init_evt) begin
          if (in_k == 4'b0000) begin m_word = in_word; m_k = 4'b0000; end
          m_armed = 1; m_elapsed = 1;
        end else if (m_armed) begin
          if (in_k == 4'b0000) begin
            m_word = in_word; m_k = 4'b0000;
          end else if (m_elapsed >= lat_cfg) begin
            m_word = {8'hF7, err_code, evt_id}; m_k = 4'b1000; m_pulse = 1;
            m_armed = 0;
          end
          if (m_elapsed < 65535) m_elapsed = m_elapsed + 1;
        end else if (in_k == 4'b0000) begin
          m_late = 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (eoe_pulse) dut_pulses++;
      check(out_word == m_word && out_k == m_k, cur_req, "word/k",
            {28'd0, out_k, out_word}, {28'd0, m_k, m_word});
      check(eoe_pulse == m_pulse, cur_req, "eoe_pulse", 64'(eoe_pulse), 64'(m_pulse));
      check(late_road == m_late, cur_req, "late_road", 64'(late_road), 64'(m_late));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic put(input logic [31:0] w, input logic [3:0] k, input bit ini);
    in_word = w; in_k = k; init_evt = ini;
    tick();
  endtask

  task automatic road(input logic [31:0] w);  put(w, 4'b0000, 0); endtask
  task automatic idle_in();                   put(32'hBCBC1C1C, 4'b1111, 0); endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    check(out_word == 32'h0000BC50 && out_k == 4'b0010 && !eoe_pulse && !late_road,
          "R1", "reset outputs", {28'd0, out_k, out_word}, {28'd0, 4'b0010, 32'h0000BC50});
    en = 1'b1;

    // R8: road before any init is dropped and flagged
    cur_req = "R8";
    road(32'hA1000001);
    idle_in();
    check(late_road == 1'b1, "R8", "late after pre-init road", 64'(late_road), 64'd1);

    // R2/R4/R5: latency 5, roads beyond latency, then gap closes
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    check(late_road == 1'b0, "R8", "late cleared by reset", 64'(late_road), 64'd0);
    cur_req = "R5"; lat_cfg = 16'd5; evt_id = 16'h1234; err_code = 8'h5A;
    p0 = dut_pulses;
    put(32'hBCBC1C1C, 4'b1111, 1);
    cur_req = "R2";
    for (int i = 0; i < 8; i++) road(32'h3C000100 + 32'(i));
    cur_req = "R4";
    idle_in();
    idle_in();
    check(dut_pulses - p0 == 1, "R7", "one eoe per init", 64'(dut_pulses - p0), 64'd1);

    // R5 boundary: gaps before latency must not close; closes at k == N
    cur_req = "R5"; lat_cfg = 16'd10; evt_id = 16'hBEEF; err_code = 8'h03;
    p0 = dut_pulses;
    put(32'hBCBC1C1C, 4'b1111, 1);
    road(32'h01ABCDEF);
    road(32'h02ABCDEE);
    for (int i = 0; i < 6; i++) idle_in();
    check(dut_pulses == p0, "R5", "no eoe before latency", 64'(dut_pulses - p0), 64'd0);
    idle_in(); idle_in(); idle_in();
    check(dut_pulses - p0 == 1, "R5", "eoe at latency", 64'(dut_pulses - p0), 64'd1);

    // R8: roads after closure dropped, flag sticky
    cur_req = "R8";
    road(32'hFF000042);
    road(32'hFF000043);
    idle_in();
    check(late_road == 1'b1, "R8", "late after post-eoe road", 64'(late_road), 64'd1);

    // R7: re-arm mid-event restarts count; road in init cycle forwarded
    cur_req = "R7"; lat_cfg = 16'd4; evt_id = 16'h0007;
    p0 = dut_pulses;
    put(32'hBCBC1C1C, 4'b1111, 1);
    idle_in(); idle_in();
    put(32'h77000055, 4'b0000, 1);
    idle_in(); idle_in(); idle_in();
    check(dut_pulses == p0, "R7", "restart delayed eoe", 64'(dut_pulses - p0), 64'd0);
    idle_in(); idle_in();
    check(dut_pulses - p0 == 1, "R7", "eoe after re-arm", 64'(dut_pulses - p0), 64'd1);

    // R5: N = 0 closes on first gap; R3: other K pattern counts as gap
    cur_req = "R3"; lat_cfg = 16'd0; evt_id = 16'hC0DE; err_code = 8'hE1;
    put(32'hBCBC1C1C, 4'b1111, 1);
    road(32'h11223344);
    put(32'h12345678, 4'b0001, 0);
    idle_in(); idle_in();

    // R9: enable low ignores init and roads, freezes count
    cur_req = "R9"; lat_cfg = 16'd3; evt_id = 16'h9999;
    p0 = dut_pulses;
    put(32'hBCBC1C1C, 4'b1111, 1);
    en = 1'b0;
    put(32'hBCBC1C1C, 4'b1111, 1);
    road(32'h55000001);
    for (int i = 0; i < 5; i++) idle_in();
    check(dut_pulses == p0, "R9", "no eoe while disabled", 64'(dut_pulses - p0), 64'd0);
    en = 1'b1;
    idle_in();
    check(dut_pulses == p0, "R9", "count frozen while disabled", 64'(dut_pulses - p0), 64'd0);
    idle_in(); idle_in(); idle_in();
    check(dut_pulses - p0 == 1, "R6", "pulse after enable resumes", 64'(dut_pulses - p0), 64'd1);

    repeat (3) idle_in();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule